// File: doc/BRIEF.md
# Adaptive voltage bus read master

This block performs one read transaction on an adaptive-voltage serial bus: it fetches the voltage, the current or the status word of one regulator rail and returns the 16-bit reading. A single-cycle `start_i` pulse selects the quantity through a 4-bit data-type code and the rail through a 4-bit select. The block builds the 32-bit command word, protects it with a 3-bit CRC and shifts it out in serial clock mode 0. It then leaves chip select high for one serial clock period and clocks in a 32-bit reply. The reply is accepted only when its two acknowledge bits are zero. Voltage readings are in 1 mV steps and current readings are in 10 mA steps.

The serial clock comes from the system clock. The parameter `CLK_DIV` holds the divider value, which equals f_sys / (8 × f_serial) − 1, so one serial period lasts 8 × (CLK_DIV+1) system clocks. The controller has five states. IDLE moves to SEND on a start pulse. SEND moves to GAP after the 32nd falling serial edge. GAP moves to RECV after one serial period. RECV moves to DONE after the 32nd falling serial edge. DONE always moves back to IDLE after one cycle.

Top module: `avs_read_master`

## Requirements
- R1: The command word leaves `mosi_o` MSB first, 32 bits. Bits [31:30]=01, [29:28]=11 (read), [27]=0, [26:23]=`cmd_type_i` (0x0 voltage, 0x2 current, 0xE status), [22:19]=`rail_i`, [18:3] all ones.
- R2: Bits [2:0] of the command word are the remainder of dividing bits [31:3], followed by three zero bits, by x^3+x+1 (divisor 1011) in modulo-2 arithmetic.
- R3: Serial mode 0 is used. `sclk_o` is low whenever `cs_n_o` is high. The first command bit is on `mosi_o` when chip select falls. Exactly 32 rising `sclk_o` edges occur in the command frame.
- R4: Between the command frame and the reply frame, `cs_n_o` stays high for exactly 8×(CLK_DIV+1) system clocks, which is one serial period.
- R5: The reply is sampled from `miso_i` on rising `sclk_o` edges, MSB first, 32 bits. Its layout is [31:30] acknowledge, [29] zero, [28:24] status, [23:8] data, [7:0] trailer.
- R6: When the acknowledge is 00, `data_o` takes reply bits [23:8], `ack_err_o` is 0 and `resp_status_o` takes bits [28:24].
- R7: When the acknowledge is not 00, `ack_err_o` is 1 and `data_o` is 0.
- R8: `busy_o` rises in the cycle after the accepted start and stays high through the single-cycle `done_o` pulse. It is low in the cycle after `done_o`, and `cs_n_o` is high whenever `busy_o` is low.
- R9: A start while `busy_o` is high does not change the running transaction and starts no other one. From the next cycle on, `wwb_err_o` is 1 and stays 1.
- R10: `clr_err_i` clears `wwb_err_o` in the next cycle. If it coincides with a start while busy, the error stays set.
- R11: After reset, `cs_n_o`=1, `sclk_o`=0, `busy_o`=0, `done_o`=0, `data_o`=0, `ack_err_o`=0 and `wwb_err_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse for one read |
| cmd_type_i | input | 4 | Data-type code of the read |
| rail_i | input | 4 | Rail select |
| clr_err_i | input | 1 | Clears the sticky start-while-busy error |
| sclk_o | output | 1 | Serial clock, idle low |
| cs_n_o | output | 1 | Active-low chip select |
| mosi_o | output | 1 | Serial command data |
| miso_i | input | 1 | Serial reply data |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | Single-cycle completion pulse |
| data_o | output | 16 | Reading; zero on acknowledge error |
| resp_status_o | output | 5 | Status field of the last reply |
| ack_err_o | output | 1 | Last reply had a non-zero acknowledge |
| wwb_err_o | output | 1 | Sticky start-while-busy error |

## Verification
Two functions can act on the sticky error flag in the same cycle: setting it because of a start while busy, and clearing it on `clr_err_i`. The bench drives both inputs on the same clock edge in the middle of a transfer and expects the flag to read 1 afterwards. It then applies the clear alone and expects 0. The bench also pulses start in the middle of a transfer. The scoreboard then requires that the returned word matches the first request and that no further completion appears.

// File: rtl/avs_pkg.sv
package avs_pkg;

    localparam int FRAME_W = 32;
    localparam int CRC_W   = 3;
    localparam int BODY_W  = FRAME_W - CRC_W;

    localparam logic [1:0] START_CODE = 2'b01;
    localparam logic [1:0] OP_READ    = 2'b11;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEND,
        ST_GAP,
        ST_RECV,
        ST_DONE
    } avs_state_e;

    // One serial step of the x^3+x+1 remainder register.
    function automatic logic [2:0] crc3_step(input logic [2:0] rem, input logic din);
        logic fb;
        fb = rem[2] ^ din;
        return {rem[1], rem[0] ^ fb, fb};
    endfunction

endpackage

// File: rtl/avs_crc3.sv
module avs_crc3 #(
    parameter int DATA_W = 29
) (
    input  logic [DATA_W-1:0] data_i,
    output logic [2:0]        crc_o
);
    import avs_pkg::*;

    logic [2:0] rem [DATA_W+1];

    assign rem[0] = 3'b000;

    genvar i;
    generate
        for (i = 0; i < DATA_W; i++) begin : g_bit
            assign rem[i+1] = crc3_step(rem[i], data_i[DATA_W-1-i]);
        end
    endgenerate

    assign crc_o = rem[DATA_W];

endmodule

// File: rtl/avs_half_tick.sv
module avs_half_tick #(
    parameter int CLK_DIV = 0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int HALF   = 4 * (CLK_DIV + 1);
    localparam int CNT_W  = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_i || cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick_o = run_i && (cnt_q == LAST);

    // Half periods are at least four clocks, so ticks never sit back to back (R4).
    p_tick_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);

endmodule

// File: rtl/avs_read_master.sv
module avs_read_master #(
    parameter int CLK_DIV = 0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic [3:0]  cmd_type_i,
    input  logic [3:0]  rail_i,
    input  logic        clr_err_i,
    output logic        sclk_o,
    output logic        cs_n_o,
    output logic        mosi_o,
    input  logic        miso_i,
    output logic        busy_o,
    output logic        done_o,
    output logic [15:0] data_o,
    output logic [4:0]  resp_status_o,
    output logic        ack_err_o,
    output logic        wwb_err_o
);
    import avs_pkg::*;

    localparam int BIT_W  = $clog2(FRAME_W);
    localparam int CAP_W  = 23;                 // ack(2) + status(5) + data(16)
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_W - 1);
    localparam logic [BIT_W-1:0] ZERO_BIT = BIT_W'(2);    // reply bit 29
    localparam logic [BIT_W-1:0] CAP_END  = BIT_W'(24);   // bits after index 23 are trailer

    avs_state_e state_q, state_d;

    logic [FRAME_W-1:0] tx_q;
    logic [CAP_W-1:0]   cap_q;
    logic [BIT_W-1:0]   bit_q;
    logic               sclk_q, cs_n_q, gap_q, done_q;
    logic [15:0]        data_q;
    logic [4:0]         stat_q;
    logic               ackerr_q, wwb_q;
    logic               tick;
    logic               last_fall;

    logic [BODY_W-1:0]  body;
    logic [CRC_W-1:0]   crc;

    assign body = {START_CODE, OP_READ, 1'b0, cmd_type_i, rail_i, 16'hFFFF};

    avs_crc3 #(.DATA_W(BODY_W)) u_crc (
        .data_i (body),
        .crc_o  (crc)
    );

    avs_half_tick #(.CLK_DIV(CLK_DIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (busy_o),
        .tick_o (tick)
    );

    assign last_fall = tick && sclk_q && (bit_q == LAST_BIT);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i)         state_d = ST_SEND;
            ST_SEND: if (last_fall)       state_d = ST_GAP;
            ST_GAP:  if (tick && gap_q)   state_d = ST_RECV;
            ST_RECV: if (last_fall)       state_d = ST_DONE;
            ST_DONE:                      state_d = ST_IDLE;
        endcase
    end

    // Outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q     <= '0;
            cap_q    <= '0;
            bit_q    <= '0;
            sclk_q   <= 1'b0;
            cs_n_q   <= 1'b1;
            gap_q    <= 1'b0;
            done_q   <= 1'b0;
            data_q   <= '0;
            stat_q   <= '0;
            ackerr_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        tx_q   <= {body, crc};
                        cs_n_q <= 1'b0;
                        sclk_q <= 1'b0;
                        bit_q  <= '0;
                    end
                end
                ST_SEND: begin
                    if (tick) begin
                        if (!sclk_q) begin
                            sclk_q <= 1'b1;
                        end else begin
                            sclk_q <= 1'b0;
                            if (bit_q == LAST_BIT) begin
                                cs_n_q <= 1'b1;
                                tx_q   <= '0;
                                bit_q  <= '0;
                                gap_q  <= 1'b0;
                            end else begin
                                tx_q  <= {tx_q[FRAME_W-2:0], 1'b0};
                                bit_q <= bit_q + 1'b1;
                            end
                        end
                    end
                end
                ST_GAP: begin
                    if (tick) begin
                        if (gap_q) begin
                            cs_n_q <= 1'b0;
                            gap_q  <= 1'b0;
                        end else begin
                            gap_q  <= 1'b1;
                        end
                    end
                end
                ST_RECV: begin
                    if (tick) begin
                        if (!sclk_q) begin
                            sclk_q <= 1'b1;
                            if (bit_q != ZERO_BIT && bit_q < CAP_END) begin
                                cap_q <= {cap_q[CAP_W-2:0], miso_i};
                            end
                        end else begin
                            sclk_q <= 1'b0;
                            if (bit_q == LAST_BIT) begin
                                cs_n_q   <= 1'b1;
                                done_q   <= 1'b1;
                                stat_q   <= cap_q[20:16];
                                ackerr_q <= (cap_q[22:21] != 2'b00);
                                data_q   <= (cap_q[22:21] == 2'b00) ? cap_q[15:0] : 16'h0000;
                            end else begin
                                bit_q <= bit_q + 1'b1;
                            end
                        end
                    end
                end
                ST_DONE: begin
                    bit_q <= '0;
                end
            endcase
        end
    end

    // Sticky start-while-busy error; setting wins over clearing.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           wwb_q <= 1'b0;
        else if (start_i && state_q != ST_IDLE) wwb_q <= 1'b1;
        else if (clr_err_i)                   wwb_q <= 1'b0;
    end

    assign busy_o        = (state_q != ST_IDLE);
    assign sclk_o        = sclk_q;
    assign cs_n_o        = cs_n_q;
    assign mosi_o        = tx_q[FRAME_W-1];
    assign done_o        = done_q;
    assign data_o        = data_q;
    assign resp_status_o = stat_q;
    assign ack_err_o     = ackerr_q;
    assign wwb_err_o     = wwb_q;

    p_sclk_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> !sclk_o);

    p_idle_cs_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> cs_n_o);

    p_done_in_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> busy_o);

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));

    p_err_zero_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ack_err_o |-> (data_o == 16'h0000));

    p_wwb_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && busy_o) |=> wwb_err_o);

    p_wwb_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_err_i && !(start_i && busy_o)) |=> !wwb_err_o);

endmodule

// File: tb/tb_avs_read_master.sv
module tb_avs_read_master;

    localparam int CLK_DIV = 0;
    localparam int GAP_EXP = 8 * (CLK_DIV + 1);

    typedef struct {
        logic [31:0] frame;
        logic [15:0] data;
        logic [4:0]  status;
        logic        err;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [3:0]  cmd_type_i = 4'h0;
    logic [3:0]  rail_i = 4'h0;
    logic        clr_err_i = 1'b0;
    logic        sclk_o, cs_n_o, mosi_o;
    logic        miso_i = 1'b0;
    logic        busy_o, done_o, ack_err_o, wwb_err_o;
    logic [15:0] data_o;
    logic [4:0]  resp_status_o;

    int n_chk = 0;
    int n_fail = 0;

    exp_t        exp_q[$];
    logic [31:0] resp_q[$];

    logic [31:0] sl_frame;
    int          sl_rise;
    int          sl_gap;

    always #4 clk = ~clk;

    avs_read_master #(.CLK_DIV(CLK_DIV)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmd_type_i(cmd_type_i),
        .rail_i(rail_i), .clr_err_i(clr_err_i), .sclk_o(sclk_o), .cs_n_o(cs_n_o),
        .mosi_o(mosi_o), .miso_i(miso_i), .busy_o(busy_o), .done_o(done_o),
        .data_o(data_o), .resp_status_o(resp_status_o), .ack_err_o(ack_err_o),
        .wwb_err_o(wwb_err_o)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Long division by 1011 over the 29-bit body followed by three zeros.
    function automatic logic [31:0] make_frame(input logic [3:0] t, input logic [3:0] r);
        logic [31:0] v;
        logic [31:0] f;
        f = {2'b01, 2'b11, 1'b0, t, r, 16'hFFFF, 3'b000};
        v = f;
        for (int i = 31; i >= 3; i--) begin
            if (v[i]) v = v ^ (32'hB << (i - 3));
        end
        return f | {29'd0, v[2:0]};
    endfunction

    // Slave model on the serial link.
    initial begin
        logic [31:0] cap;
        logic [31:0] resp;
        logic        prev;
        int          idx;
        forever begin
            do @(negedge clk); while (cs_n_o);
            resp = (resp_q.size() > 0) ? resp_q.pop_front() : 32'h0;
            cap = '0; sl_rise = 0; prev = 1'b0;
            while (!cs_n_o) begin
                if (sclk_o && !prev) begin
                    cap = {cap[30:0], mosi_o};
                    sl_rise++;
                end
                prev = sclk_o;
                @(negedge clk);
            end
            sl_frame = cap;
            sl_gap = 0;
            while (cs_n_o) begin
                sl_gap++;
                @(negedge clk);
            end
            idx = 31; miso_i = resp[31]; prev = 1'b0;
            while (!cs_n_o) begin
                if (!sclk_o && prev && idx > 0) begin
                    idx--;
                    miso_i = resp[idx];
                end
                prev = sclk_o;
                @(negedge clk);
            end
            miso_i = 1'b0;
        end
    end

    // Scoreboard monitor.
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            if (rst_n && done_o) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R9 unexpected completion", 32'd1, 32'd0);
                end else begin
                    e = exp_q.pop_front();
                    chk(sl_frame[31:3] == e.frame[31:3], "R1 command body", sl_frame, e.frame);
                    chk(sl_frame[2:0] == e.frame[2:0], "R2 crc", {29'd0, sl_frame[2:0]}, {29'd0, e.frame[2:0]});
                    chk(sl_rise == 32, "R3 rising edges", sl_rise, 32);
                    chk(sl_gap == GAP_EXP, "R4 gap length", sl_gap, GAP_EXP);
                    chk(data_o == e.data, "R6/R7 data", {16'd0, data_o}, {16'd0, e.data});
                    chk(ack_err_o == e.err, "R7 ack error", {31'd0, ack_err_o}, {31'd0, e.err});
                    chk(resp_status_o == e.status, "R5 status", {27'd0, resp_status_o}, {27'd0, e.status});
                end
            end
        end
    end

    // Driver: pushes expected result and reply, then runs one read.
    task automatic run_read(input logic [3:0] t, input logic [3:0] r, input logic [1:0] ack,
                            input logic [4:0] st, input logic [15:0] d, input bit poke);
        exp_t e;
        e.frame  = make_frame(t, r);
        e.err    = (ack != 2'b00);
        e.data   = e.err ? 16'h0 : d;
        e.status = st;
        exp_q.push_back(e);
        resp_q.push_back({ack, 1'b0, st, d, 5'h1F, 3'b000});
        @(negedge clk);
        cmd_type_i = t; rail_i = r; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o == 1'b1, "R8 busy after start", {31'd0, busy_o}, 32'd1);
        if (poke) begin
            repeat (40) @(negedge clk);
            cmd_type_i = ~t; rail_i = ~r; start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            chk(wwb_err_o == 1'b1, "R9 sticky error set", {31'd0, wwb_err_o}, 32'd1);
        end
        while (!done_o) @(negedge clk);
        @(negedge clk);
        chk(busy_o == 1'b0, "R8 busy drops after done", {31'd0, busy_o}, 32'd0);
        if (poke) begin
            repeat (30) @(negedge clk);
            chk(busy_o == 1'b0 && cs_n_o == 1'b1, "R9 no second transfer", {30'd0, busy_o, cs_n_o}, 32'd1);
        end
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                chk(cs_n_o == 1'b1 && sclk_o == 1'b0, "R11 link idle in reset", {30'd0, cs_n_o, sclk_o}, 32'd2);
                rst_n = 1'b1;
                @(negedge clk);
                chk(busy_o == 0 && done_o == 0 && data_o == 0, "R11 reset outputs", {15'd0, busy_o, done_o, data_o}, 32'd0);
                chk(ack_err_o == 0 && wwb_err_o == 0, "R11 reset errors", {30'd0, ack_err_o, wwb_err_o}, 32'd0);

                run_read(4'h0, 4'h3, 2'b00, 5'h00, 16'h1234, 1'b0);   // voltage, R1 R6
                run_read(4'h2, 4'hF, 2'b00, 5'h15, 16'hBEEF, 1'b0);   // current
                run_read(4'hE, 4'h0, 2'b00, 5'h0A, 16'h8001, 1'b0);   // status
                run_read(4'h0, 4'h7, 2'b01, 5'h1F, 16'hFFFF, 1'b0);   // R7 ack 01
                run_read(4'h2, 4'h9, 2'b10, 5'h03, 16'h5A5A, 1'b0);   // R7 ack 10
                run_read(4'h0, 4'h1, 2'b11, 5'h11, 16'h0F0F, 1'b0);   // R7 ack 11
                run_read(4'h2, 4'h5, 2'b00, 5'h07, 16'hC3A5, 1'b1);   // R9 poke

                // R10: set and clear in the same cycle, then clear alone.
                exp_q.push_back('{make_frame(4'h0, 4'hA), 16'h0777, 5'h02, 1'b0});
                resp_q.push_back({2'b00, 1'b0, 5'h02, 16'h0777, 5'h1F, 3'b000});
                @(negedge clk);
                cmd_type_i = 4'h0; rail_i = 4'hA; start_i = 1'b1;
                @(negedge clk);
                start_i = 1'b0;
                repeat (20) @(negedge clk);
                start_i = 1'b1; clr_err_i = 1'b1;
                @(negedge clk);
                start_i = 1'b0; clr_err_i = 1'b0;
                chk(wwb_err_o == 1'b1, "R10 set wins over clear", {31'd0, wwb_err_o}, 32'd1);
                clr_err_i = 1'b1;
                @(negedge clk);
                clr_err_i = 1'b0;
                chk(wwb_err_o == 1'b0, "R10 clear alone", {31'd0, wwb_err_o}, 32'd0);
                while (!done_o) @(negedge clk);
                repeat (3) @(negedge clk);
                chk(exp_q.size() == 0, "R8 all completions seen", exp_q.size(), 0);
            end
            begin
                repeat (150000) @(posedge clk);
                chk(1'b0, "watchdog expired", 32'd1, 32'd0);
            end
        join_any
        disable fork;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule